// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

This block is one DMA channel engine. It walks a ring of 8-byte buffer descriptors kept in system memory and moves packet bytes between the buffers those descriptors point to and a byte-wide stream port. One elaboration parameter picks the direction. In receive mode, bytes from the stream are written into memory. In transmit mode, bytes are read from memory and presented on the stream. Software builds descriptors, gives each one to the engine by setting its ownership bit, and then starts the channel. The engine processes owned descriptors in ring order. It writes each one back with the ownership bit cleared and follows per-descriptor wrap marks back to the ring start.

A small register interface holds four things: the channel control word (start and two kinds of halt request), a maximum descriptors-per-activation count, the ring start address and the read-only current descriptor address. Memory is reached through a single request port of 32-bit words with byte enables. A request is held until the memory acknowledges it. A dedicated channel reset abandons any transfer and rewinds the channel to the ring start.

Top module: `dma_ring_chan`

## Requirements
- R1: A descriptor at address D is two little-endian words. The word at D holds the length in bits 15:0 and the status in bits 31:16. The word at D+4 holds the buffer address. Buffer byte at address A travels on byte lane A[1:0]. A memory request, once raised, keeps its address until it is acknowledged.
- R2: Writing control (register 0) with bit 0 set on a stopped channel starts it at the current descriptor address. Control bit 0 reads 1 while the channel runs and 0 once it has stopped.
- R3: A fetched descriptor whose status bit 15 (owned by engine) is clear stops the channel. Nothing is written, and the current descriptor address stays unchanged.
- R4: Every completed descriptor is written back with status bit 15 cleared.
- R5: After a descriptor with status bit 12 (ring end) set, the current address returns to the ring start. Otherwise it advances by 8.
- R6: Transmit sends the descriptor's length in bytes, in address order. The end-of-stream flag marks the final byte only when status bit 14 (packet end) is set. The CRC-append flag copies status bit 8 on every byte. Write-back keeps the length and the other status bits.
- R7: Receive stores bytes from the buffer address upward. Write-back gives length = bytes stored. Status has bits 14 and 13 set, bit 12 kept, bit 1 equal to the stream error flag seen with the last byte, and all other bits zero.
- R8: In receive mode, bytes beyond the buffer length are dropped up to the end of the packet, and status bit 4 (oversize) is set.
- R9: A nonzero value N in register 1 stops the channel after N descriptors in one activation. Zero means no limit.
- R10: Control bit 2 (halt at burst boundary) stops the channel once the current descriptor completes.
- R11: Control bit 1 (halt at packet boundary) stops the channel after the next descriptor with status bit 14 set. Descriptors without it are processed through.
- R12: Channel reset stops the channel at once and returns the current address to the ring start. The descriptor in progress is not written back.
- R13: Register 2 is the ring start. Writing it while stopped also moves the current address there. Register 3 reads the current descriptor address. Every register reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanRst | input | 1 | Channel reset: abort and rewind |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write value |
| regRdData | output | 32 | Register read value (combinational) |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Request is a write |
| memBe | output | 4 | Byte enables of a write |
| memAddr | output | 32 | Byte address of the request |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Memory acknowledge, one cycle |
| memRdata | input | 32 | Read data, valid with acknowledge |
| inValid | input | 1 | Receive byte valid |
| inData | input | 8 | Receive byte |
| inLast | input | 1 | Receive byte ends the packet |
| inCrcErr | input | 1 | Packet error flag, sampled with the last byte |
| inReady | output | 1 | Engine accepts a receive byte |
| outValid | output | 1 | Transmit byte valid |
| outData | output | 8 | Transmit byte |
| outLast | output | 1 | Transmit byte ends the packet |
| outCrc | output | 1 | Packet wants CRC appended |
| outReady | input | 1 | Sink takes the transmit byte |

## Verification
A corrupted descriptor pointer appears on memAddr at the very next descriptor fetch, which comes two cycles after the previous write-back is acknowledged. It also appears at once in the register 3 read-back. A miscounted byte index shows up as a wrong byte lane or address on the next data access, and later as a wrong length in the write-back word. A halt or burst-count register left in the wrong state shows up as the channel stopping one descriptor early or late, and can be seen through control bit 0 and the ownership bits still set in memory.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned BIT_OWN  = 15;
  localparam int unsigned BIT_EOP  = 14;
  localparam int unsigned BIT_SOP  = 13;
  localparam int unsigned BIT_WRAP = 12;
  localparam int unsigned BIT_CRC  = 8;
  localparam int unsigned DESC_BYTES = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH0, ST_FETCH1, ST_RD, ST_OUT, ST_IN, ST_WR, ST_WBACK, ST_NEXT
  } chanState_e;

  typedef enum logic [1:0] {SEL_DESC0, SEL_DESC1, SEL_DATA} memSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic ldWord0;
    logic ldWord1;
    logic ldByteRd;
    logic takeIn;
    logic incByte;
    logic advance;
    logic rewind;
  } dpStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic rdOwn;
    logic lenZero;
    logic byteRoom;
    logic txLastByte;
    logic descEop;
    logic descCrc;
    logic lastSeen;
  } dpFlags_t;
endpackage

// File: rtl/dma_ring_dp.sv
module dma_ring_dp
  import dma_ring_pkg::*;
#(
  parameter bit IS_RX = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  memSel_e           memSel,
  input  logic              ringWr,
  input  logic [ADDR_W-1:0] ringVal,
  input  logic              idle,
  input  logic [31:0]       memRdata,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic              inCrcErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  output logic [7:0]        outData,
  output dpFlags_t          flags,
  output logic [ADDR_W-1:0] ringStart,
  output logic [ADDR_W-1:0] descAddr
);
  logic [15:0]       descLen, descStatus, byteCnt;
  logic [ADDR_W-1:0] bufAddr, dataAddr;
  logic [7:0]        byteReg, laneByte;
  logic              overFlag, crcFlag, lastFlag;
  logic [15:0]       wbStatus, wbLen;

  assign dataAddr = bufAddr + {{(ADDR_W-16){1'b0}}, byteCnt};
  assign laneByte = 8'(memRdata >> {dataAddr[1:0], 3'b000});

  generate
    if (IS_RX) begin : g_rxWb
      assign wbStatus = {1'b0, 1'b1, 1'b1, descStatus[BIT_WRAP], 7'd0, overFlag, 2'd0, crcFlag, 1'b0};
      assign wbLen    = byteCnt;
    end else begin : g_txWb
      assign wbStatus = descStatus & ~(16'd1 << BIT_OWN);
      assign wbLen    = descLen;
    end
  endgenerate

  always_comb begin
    case (memSel)
      SEL_DESC1: memAddr = descAddr + ADDR_W'(4);
      SEL_DATA:  memAddr = dataAddr;
      default:   memAddr = descAddr;
    endcase
    memWdata = (memSel == SEL_DATA) ? {4{byteReg}} : {wbStatus, wbLen};
    memBe    = (memSel == SEL_DATA) ? (4'b0001 << dataAddr[1:0]) : 4'hF;
  end

  assign outData          = byteReg;
  assign flags.rdOwn      = memRdata[16 + BIT_OWN];
  assign flags.lenZero    = (descLen == 16'd0);
  assign flags.byteRoom   = (byteCnt < descLen);
  assign flags.txLastByte = (({1'b0, byteCnt} + 17'd1) == {1'b0, descLen});
  assign flags.descEop    = IS_RX ? 1'b1 : descStatus[BIT_EOP];
  assign flags.descCrc    = descStatus[BIT_CRC];
  assign flags.lastSeen   = lastFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringStart  <= '0;
      descAddr   <= '0;
      descLen    <= '0;
      descStatus <= '0;
      bufAddr    <= '0;
      byteCnt    <= '0;
      byteReg    <= '0;
      overFlag   <= 1'b0;
      crcFlag    <= 1'b0;
      lastFlag   <= 1'b0;
    end else begin
      if (ringWr) ringStart <= ringVal;
      if (strb.rewind)         descAddr <= ringStart;
      else if (ringWr && idle) descAddr <= ringVal;
      else if (strb.advance)
        descAddr <= descStatus[BIT_WRAP] ? ringStart : descAddr + ADDR_W'(DESC_BYTES);

      if (strb.rewind || strb.ldWord0) begin
        byteCnt  <= '0;
        overFlag <= 1'b0;
        crcFlag  <= 1'b0;
        lastFlag <= 1'b0;
      end else begin
        if (strb.incByte) byteCnt <= byteCnt + 16'd1;
        if (strb.takeIn) begin
          if (!flags.byteRoom) overFlag <= 1'b1;
          if (inLast) lastFlag <= 1'b1;
          crcFlag <= crcFlag | (inLast & inCrcErr);
        end
      end
      if (strb.ldWord0) begin
        descLen    <= memRdata[15:0];
        descStatus <= memRdata[31:16];
      end
      if (strb.ldWord1) bufAddr <= memRdata;
      if (strb.ldByteRd) byteReg <= laneByte;
      else if (strb.takeIn && flags.byteRoom) byteReg <= inData;
    end
  end

  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && !strb.rewind && descStatus[BIT_WRAP] |=> descAddr == $past(ringStart)); // R5
  AST_STEP_EIGHT: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && !strb.rewind && !descStatus[BIT_WRAP] |=> descAddr == $past(descAddr) + ADDR_W'(DESC_BYTES)); // R5
endmodule

// File: rtl/dma_ring_ctrl.sv
module dma_ring_ctrl
  import dma_ring_pkg::*;
#(
  parameter bit IS_RX   = 1'b0,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chanRst,
  input  logic               cfgWr,
  input  logic [2:0]         cfgBits,
  input  logic               burstWr,
  input  logic [BURST_W-1:0] burstVal,
  input  logic               memAck,
  input  dpFlags_t           flags,
  input  logic               inValid,
  input  logic               inLast,
  input  logic               outReady,
  output logic               memReq,
  output logic               memWe,
  output memSel_e            memSel,
  output logic               inReady,
  output logic               outValid,
  output logic               outLast,
  output logic               outCrc,
  output dpStrobe_t          strb,
  output logic               running,
  output logic               haltPkt,
  output logic               haltBurst,
  output logic [BURST_W-1:0] maxBurst
);
  chanState_e         state, nxt;
  logic [BURST_W-1:0] burstCnt, burstNext;
  logic               startReq, limitHit, stopAtNext;

  assign startReq   = cfgWr && cfgBits[0] && (state == ST_IDLE);
  assign burstNext  = burstCnt + BURST_W'(1);
  assign limitHit   = (maxBurst != '0) && (burstNext == maxBurst);
  assign stopAtNext = haltBurst || (haltPkt && flags.descEop) || limitHit;
  assign running    = (state != ST_IDLE);
  assign outLast    = outValid && flags.descEop && flags.txLastByte;
  assign outCrc     = outValid && flags.descCrc;

  always_comb begin
    nxt         = state;
    memReq      = 1'b0;
    memWe       = 1'b0;
    memSel      = SEL_DESC0;
    inReady     = 1'b0;
    outValid    = 1'b0;
    strb        = '0;
    strb.rewind = chanRst;
    case (state)
      ST_IDLE: if (startReq) nxt = ST_FETCH0;
      ST_FETCH0: begin
        memReq = 1'b1;
        if (memAck) begin
          if (!flags.rdOwn) nxt = ST_IDLE;
          else begin
            strb.ldWord0 = 1'b1;
            nxt = ST_FETCH1;
          end
        end
      end
      ST_FETCH1: begin
        memReq = 1'b1;
        memSel = SEL_DESC1;
        if (memAck) begin
          strb.ldWord1 = 1'b1;
          if (IS_RX) nxt = ST_IN;
          else nxt = flags.lenZero ? ST_WBACK : ST_RD;
        end
      end
      ST_RD: begin
        memReq = 1'b1;
        memSel = SEL_DATA;
        if (memAck) begin
          strb.ldByteRd = 1'b1;
          nxt = ST_OUT;
        end
      end
      ST_OUT: begin
        outValid = 1'b1;
        if (outReady) begin
          strb.incByte = 1'b1;
          nxt = flags.txLastByte ? ST_WBACK : ST_RD;
        end
      end
      ST_IN: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.takeIn = 1'b1;
          if (flags.byteRoom) nxt = ST_WR;
          else if (inLast) nxt = ST_WBACK;
        end
      end
      ST_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        memSel = SEL_DATA;
        if (memAck) begin
          strb.incByte = 1'b1;
          nxt = flags.lastSeen ? ST_WBACK : ST_IN;
        end
      end
      ST_WBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) nxt = ST_NEXT;
      end
      ST_NEXT: begin
        strb.advance = 1'b1;
        nxt = stopAtNext ? ST_IDLE : ST_FETCH0;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) maxBurst <= '0;
    else if (burstWr) maxBurst <= burstVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN || chanRst) begin
      state     <= ST_IDLE;
      haltPkt   <= 1'b0;
      haltBurst <= 1'b0;
      burstCnt  <= '0;
    end else begin
      state <= nxt;
      if (startReq) begin
        burstCnt  <= '0;
        haltPkt   <= cfgBits[1];
        haltBurst <= cfgBits[2];
      end else if (nxt == ST_IDLE) begin
        haltPkt   <= 1'b0;
        haltBurst <= 1'b0;
      end else if (cfgWr) begin
        haltPkt   <= haltPkt | cfgBits[1];
        haltBurst <= haltBurst | cfgBits[2];
      end
      if (state == ST_NEXT) burstCnt <= burstNext;
    end
  end

  AST_RESET_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    chanRst |=> !running && !memReq); // R12
  AST_IDLE_NO_HALT: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !haltPkt && !haltBurst); // R10
  AST_STREAM_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && (outValid || memReq))); // R7
endmodule

// File: rtl/dma_ring_chan.sv
module dma_ring_chan
  import dma_ring_pkg::*;
#(
  parameter bit IS_RX   = 1'b0,
  parameter int BURST_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanRst,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic        memWe,
  output logic [3:0]  memBe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memAck,
  input  logic [31:0] memRdata,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inLast,
  input  logic        inCrcErr,
  output logic        inReady,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        outLast,
  output logic        outCrc,
  input  logic        outReady
);
  dpStrobe_t          strb;
  dpFlags_t           flags;
  memSel_e            memSel;
  logic               running, haltPkt, haltBurst;
  logic [BURST_W-1:0] maxBurst;
  logic [31:0]        ringStart, descAddr;
  logic               cfgWr, burstWr, ringWr;

  assign cfgWr   = regWrEn && (regAddr == 2'd0);
  assign burstWr = regWrEn && (regAddr == 2'd1);
  assign ringWr  = regWrEn && (regAddr == 2'd2);

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = {29'd0, haltBurst, haltPkt, running};
      2'd1:    regRdData = {{(32-BURST_W){1'b0}}, maxBurst};
      2'd2:    regRdData = ringStart;
      default: regRdData = descAddr;
    endcase
  end

  dma_ring_ctrl #(.IS_RX(IS_RX), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanRst(chanRst),
    .cfgWr(cfgWr), .cfgBits(regWrData[2:0]),
    .burstWr(burstWr), .burstVal(regWrData[BURST_W-1:0]),
    .memAck(memAck), .flags(flags),
    .inValid(inValid), .inLast(inLast), .outReady(outReady),
    .memReq(memReq), .memWe(memWe), .memSel(memSel),
    .inReady(inReady), .outValid(outValid), .outLast(outLast), .outCrc(outCrc),
    .strb(strb), .running(running), .haltPkt(haltPkt), .haltBurst(haltBurst),
    .maxBurst(maxBurst)
  );

  dma_ring_dp #(.IS_RX(IS_RX)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memSel(memSel),
    .ringWr(ringWr), .ringVal(regWrData), .idle(!running),
    .memRdata(memRdata), .inData(inData), .inLast(inLast), .inCrcErr(inCrcErr),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .outData(outData),
    .flags(flags), .ringStart(ringStart), .descAddr(descAddr)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN || chanRst)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)); // R1
  AST_OWN_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && (memBe == 4'hF) |-> !memWdata[31]); // R4
  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && (memBe != 4'hF) |-> ($countones(memBe) == 1) && (memBe[memAddr[1:0]])); // R1
endmodule

// File: tb/dma_ring_chan_tb.sv
module dma_ring_tb_mem (
  input  logic        clk,
  input  logic        rstN,
  input  logic        req,
  input  logic        we,
  input  logic [3:0]  be,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  input  logic        bdWe,
  input  logic [7:0]  bdIdx,
  input  logic [31:0] bdData
);
  logic [31:0] mem [0:255];
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= req && !ack;
      if (bdWe) mem[bdIdx] <= bdData;
      if (req && !ack) begin
        rdata <= mem[addr[9:2]];
        if (we) for (int b = 0; b < 4; b++)
          if (be[b]) mem[addr[9:2]][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end
endmodule

module dma_ring_chan_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, txRst, rxRst, txWrEn, rxWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData, txRd, rxRd;
  logic        txReq, txWe, txAck, rxReq, rxWe, rxAck;
  logic [3:0]  txBe, rxBe;
  logic [31:0] txAddr, txWdata, txRdata, rxAddr, rxWdata, rxRdata;
  logic        inValid, inLast, inCrcErr, rxInReady, txOutReady;
  logic [7:0]  inData;
  logic        txOutValid, txOutLast, txOutCrc, txInReady;
  logic [7:0]  txOutData, rxOutData;
  logic        rxOutValid, rxOutLast, rxOutCrc;
  logic        bdWeTx, bdWeRx;
  logic [7:0]  bdIdx;
  logic [31:0] bdData;

  int checks = 0;
  int errors = 0;

  dma_ring_chan #(.IS_RX(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .chanRst(rxRst), .regWrEn(rxWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rxRd), .memReq(rxReq), .memWe(rxWe), .memBe(rxBe),
    .memAddr(rxAddr), .memWdata(rxWdata), .memAck(rxAck), .memRdata(rxRdata),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inCrcErr(inCrcErr),
    .inReady(rxInReady), .outValid(rxOutValid), .outData(rxOutData), .outLast(rxOutLast),
    .outCrc(rxOutCrc), .outReady(1'b0)
  );

  dma_ring_chan #(.IS_RX(1'b0)) u_dutTx (
    .clk(clk), .rstN(rstN), .chanRst(txRst), .regWrEn(txWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(txRd), .memReq(txReq), .memWe(txWe), .memBe(txBe),
    .memAddr(txAddr), .memWdata(txWdata), .memAck(txAck), .memRdata(txRdata),
    .inValid(1'b0), .inData(8'd0), .inLast(1'b0), .inCrcErr(1'b0),
    .inReady(txInReady), .outValid(txOutValid), .outData(txOutData), .outLast(txOutLast),
    .outCrc(txOutCrc), .outReady(txOutReady)
  );

  dma_ring_tb_mem u_memRx (.clk(clk), .rstN(rstN), .req(rxReq), .we(rxWe), .be(rxBe),
    .addr(rxAddr), .wdata(rxWdata), .ack(rxAck), .rdata(rxRdata),
    .bdWe(bdWeRx), .bdIdx(bdIdx), .bdData(bdData));
  dma_ring_tb_mem u_memTx (.clk(clk), .rstN(rstN), .req(txReq), .we(txWe), .be(txBe),
    .addr(txAddr), .wdata(txWdata), .ack(txAck), .rdata(txRdata),
    .bdWe(bdWeTx), .bdIdx(bdIdx), .bdData(bdData));

  // transmit stream monitor
  logic [7:0] capData [0:63];
  logic       capLast [0:63];
  logic       capCrc  [0:63];
  int         capN = 0;
  always @(posedge clk) begin
    if (txOutValid && txOutReady && capN < 64) begin
      capData[capN] <= txOutData;
      capLast[capN] <= txOutLast;
      capCrc[capN]  <= txOutCrc;
      capN <= capN + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input bit rx, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d;
    if (rx) rxWrEn = 1'b1; else txWrEn = 1'b1;
    @(negedge clk);
    rxWrEn = 1'b0; txWrEn = 1'b0;
  endtask

  task automatic regRd(input bit rx, input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rx ? rxRd : txRd;
  endtask

  task automatic bdWrite(input bit rx, input logic [31:0] byteAddr, input logic [31:0] d);
    @(negedge clk);
    bdIdx = byteAddr[9:2]; bdData = d;
    if (rx) bdWeRx = 1'b1; else bdWeTx = 1'b1;
    @(negedge clk);
    bdWeRx = 1'b0; bdWeTx = 1'b0;
  endtask

  function automatic logic [31:0] memWord(input bit rx, input logic [31:0] byteAddr);
    return rx ? u_memRx.mem[byteAddr[9:2]] : u_memTx.mem[byteAddr[9:2]];
  endfunction

  function automatic logic [7:0] memByte(input bit rx, input logic [31:0] byteAddr);
    logic [31:0] w;
    w = memWord(rx, byteAddr);
    return w[byteAddr[1:0]*8 +: 8];
  endfunction

  task automatic setByte(input bit rx, input logic [31:0] a, input logic [7:0] v);
    logic [31:0] w;
    w = memWord(rx, a);
    w[a[1:0]*8 +: 8] = v;
    bdWrite(rx, a, w);
  endtask

  task automatic setDesc(input bit rx, input logic [31:0] a, input logic [15:0] len,
                         input logic [15:0] st, input logic [31:0] buff);
    bdWrite(rx, a, {st, len});
    bdWrite(rx, a + 4, buff);
  endtask

  task automatic waitStop(input bit rx, input string tag);
    logic [31:0] v;
    int n;
    v = 32'd1; n = 0;
    while (v[0] && n < 3000) begin
      regRd(rx, 2'd0, v);
      n++;
    end
    if (v[0]) begin
      checks++; errors++;
      $display("FAIL %s channel still running actual=1 expected=0", tag);
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input logic last, input logic err);
    @(negedge clk);
    inValid = 1'b1; inData = d; inLast = last; inCrcErr = err;
    forever begin
      if (rxInReady) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; inCrcErr = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      regRd(1'b0, 2'(a), v); check("R13 tx reg reset", v, 32'd0);
      regRd(1'b1, 2'(a), v); check("R13 rx reg reset", v, 32'd0);
    end
  endtask

  task automatic testTxBasic();
    logic [31:0] v;
    int base;
    setDesc(1'b0, 32'h100, 16'd5, 16'hE100, 32'h201);
    setDesc(1'b0, 32'h108, 16'd2, 16'h0000, 32'h210);
    for (int k = 0; k < 5; k++) setByte(1'b0, 32'h201 + k, 8'(8'h11 * (k + 1)));
    regWr(1'b0, 2'd2, 32'h100);
    regRd(1'b0, 2'd3, v); check("R13 ring start moves current", v, 32'h100);
    base = capN;
    regWr(1'b0, 2'd0, 32'h1);
    regRd(1'b0, 2'd0, v); check("R2 running reads 1", v[0], 1'b1);
    waitStop(1'b0, "R3 tx basic");
    check("R6 byte count", capN - base, 5);
    for (int k = 0; k < 5; k++) begin
      check("R1 R6 byte order", capData[base + k], 8'(8'h11 * (k + 1)));
      check("R6 crc flag", capCrc[base + k], 1'b1);
      check("R6 last flag", capLast[base + k], (k == 4));
    end
    check("R4 tx writeback", memWord(1'b0, 32'h100), 32'h6100_0005);
    regRd(1'b0, 2'd3, v); check("R3 R5 current after unowned", v, 32'h108);
    check("R3 unowned untouched", memWord(1'b0, 32'h108), 32'h0000_0002);
  endtask

  task automatic testTxWrap();
    logic [31:0] v;
    int base;
    setDesc(1'b0, 32'h108, 16'd2, 16'hF000, 32'h210);
    setByte(1'b0, 32'h210, 8'hA5);
    setByte(1'b0, 32'h211, 8'h5A);
    base = capN;
    regWr(1'b0, 2'd0, 32'h1);
    waitStop(1'b0, "R5 tx wrap");
    regRd(1'b0, 2'd3, v); check("R5 wrap to ring start", v, 32'h100);
    check("R5 wrap writeback", memWord(1'b0, 32'h108), 32'h7000_0002);
    check("R6 wrap bytes", {capData[base], capData[base + 1]}, 16'hA55A);
  endtask

  task automatic testHalts();
    logic [31:0] v;
    int base;
    setDesc(1'b0, 32'h100, 16'd1, 16'hA000, 32'h220);
    setDesc(1'b0, 32'h108, 16'd1, 16'hC000, 32'h224);
    setDesc(1'b0, 32'h110, 16'd1, 16'hF000, 32'h228);
    setByte(1'b0, 32'h220, 8'h31);
    setByte(1'b0, 32'h224, 8'h32);
    setByte(1'b0, 32'h228, 8'h33);
    base = capN;
    regWr(1'b0, 2'd0, 32'h3);
    waitStop(1'b0, "R11 packet halt");
    regRd(1'b0, 2'd3, v); check("R11 stop after packet end", v, 32'h110);
    check("R11 bytes sent", capN - base, 2);
    check("R11 last only on packet end", {capLast[base], capLast[base + 1]}, 2'b01);
    check("R11 next desc still owned", memWord(1'b0, 32'h110), 32'hF000_0001);
    setDesc(1'b0, 32'h100, 16'd1, 16'hA000, 32'h220);
    regWr(1'b0, 2'd0, 32'h5);
    waitStop(1'b0, "R10 burst halt");
    regRd(1'b0, 2'd3, v); check("R10 stop after current", v, 32'h100);
    check("R10 following desc untouched", memWord(1'b0, 32'h100), 32'hA000_0001);
    check("R10 current written back", memWord(1'b0, 32'h110), 32'h7000_0001);
  endtask

  task automatic testMaxBurst();
    logic [31:0] v;
    setDesc(1'b0, 32'h100, 16'd1, 16'hC000, 32'h220);
    setDesc(1'b0, 32'h108, 16'd1, 16'hC000, 32'h224);
    setDesc(1'b0, 32'h110, 16'd1, 16'hF000, 32'h228);
    regWr(1'b0, 2'd1, 32'd2);
    regRd(1'b0, 2'd1, v); check("R13 burst reg readback", v, 32'd2);
    regWr(1'b0, 2'd0, 32'h1);
    waitStop(1'b0, "R9 max burst");
    regRd(1'b0, 2'd3, v); check("R9 stop after two", v, 32'h110);
    check("R9 third still owned", memWord(1'b0, 32'h110), 32'hF000_0001);
    check("R9 second released", memWord(1'b0, 32'h108), 32'h4000_0001);
    regWr(1'b0, 2'd1, 32'd0);
  endtask

  task automatic testChanReset();
    logic [31:0] v;
    int base;
    txOutReady = 1'b0;
    base = capN;
    regWr(1'b0, 2'd0, 32'h1);
    repeat (20) @(negedge clk);
    regRd(1'b0, 2'd0, v); check("R2 running while stalled", v[0], 1'b1);
    @(negedge clk); txRst = 1'b1;
    @(negedge clk); txRst = 1'b0;
    regRd(1'b0, 2'd0, v); check("R12 stopped by reset", v[0], 1'b0);
    regRd(1'b0, 2'd3, v); check("R12 rewound to ring start", v, 32'h100);
    check("R12 no writeback", memWord(1'b0, 32'h110), 32'hF000_0001);
    txOutReady = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 nothing sent", capN - base, 0);
  endtask

  task automatic testRx();
    logic [31:0] v;
    setDesc(1'b1, 32'h100, 16'd4, 16'h8000, 32'h200);
    setDesc(1'b1, 32'h108, 16'd3, 16'h9000, 32'h240);
    bdWrite(1'b1, 32'h240, 32'hEEEE_EEEE);
    bdWrite(1'b1, 32'h200, 32'hEEEE_EEEE);
    regWr(1'b1, 2'd2, 32'h100);
    regWr(1'b1, 2'd0, 32'h1);
    sendByte(8'hA1, 1'b0, 1'b0);
    sendByte(8'hA2, 1'b0, 1'b0);
    sendByte(8'hA3, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) sendByte(8'(8'hB1 + k), (k == 4), (k == 4));
    waitStop(1'b1, "R7 rx");
    check("R7 rx writeback", memWord(1'b1, 32'h100), 32'h6000_0003);
    check("R7 rx data", memWord(1'b1, 32'h200), 32'hEEA3_A2A1);
    check("R8 oversize writeback", memWord(1'b1, 32'h108), 32'h7012_0003);
    check("R8 stored bytes", {memByte(1'b1, 32'h240), memByte(1'b1, 32'h241), memByte(1'b1, 32'h242)}, 24'hB1B2B3);
    check("R8 overflow dropped", memByte(1'b1, 32'h243), 8'hEE);
    regRd(1'b1, 2'd3, v); check("R5 R3 rx back at start", v, 32'h100);
  endtask

  initial begin
    rstN = 1'b0; txRst = 1'b0; rxRst = 1'b0; txWrEn = 1'b0; rxWrEn = 1'b0;
    regAddr = '0; regWrData = '0; inValid = 1'b0; inData = '0; inLast = 1'b0;
    inCrcErr = 1'b0; txOutReady = 1'b1; bdWeTx = 1'b0; bdWeRx = 1'b0;
    bdIdx = '0; bdData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 256; i++) begin
      bdWrite(1'b0, 32'(i * 4), 32'd0);
      bdWrite(1'b1, 32'(i * 4), 32'd0);
    end
    testReset();
    testTxBasic();
    testTxWrap();
    testHalts();
    testMaxBurst();
    testChanReset();
    testRx();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule